// File: doc/BRIEF.md
# Strobe-Busy Parallel Printer Port

This block feeds a stream of characters from a host to a slow parallel printer. The host offers one character at a time through a valid/ready pair. The block drives the character onto an 8-bit printer data bus and waits at least a setup interval. It then pulls an active-low strobe for a fixed number of clocks and keeps the data steady through a hold interval afterwards.

After the strobe, the block does not accept the next character until the printer has raised its busy line and dropped it again. The printer therefore sets the pace of the whole transfer. Busy reaches the control logic only through a two-stage synchronizer.

If the printer never raises busy within a timeout window, the block returns to idle without waiting for it. In that case it sets a timeout flag, and the flag stays up until the next character is accepted. While idle, the block offers ready only when the synchronized busy line is low.

Top module: `strobe_printer_port`

## Requirements
- R1: While reset is high, and in the first cycle after it, the strobe output is high, the data bus is zero, the timeout flag is low, and (with busy low) ready is high.
- R2: Ready is high only when the block is idle and synchronized busy is low. A character is taken at a clock edge where valid and ready are both high. Ready is never high while the strobe is low.
- R3: The data bus takes the accepted character in the cycle after acceptance and changes at no other time. It is presented at least SETUP_CYC clocks before the strobe falls, stays stable while the strobe is low, and stays stable for at least HOLD_CYC clocks after the strobe rises.
- R4: Each accepted character produces exactly one strobe pulse, low for exactly STROBE_CYC clocks.
- R5: After the strobe, ready stays low until busy has been seen high and then low. Ready rises on the third clock edge after busy falls: two synchronizer stages plus one state update.
- R6: Valid offered while busy is high is ignored. No strobe is produced and the data bus keeps its previous character.
- R7: If busy is not seen high within TIMEOUT_CYC clocks after the hold interval, the block returns to idle and sets the timeout flag. Ready then returns exactly HOLD_CYC + TIMEOUT_CYC clocks after the strobe rises.
- R8: The timeout flag is cleared in the cycle after the next character is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Host has a character to send |
| in_data | input | DATA_W | Host character |
| in_ready | output | 1 | Block will take a character at this edge |
| prn_data | output | DATA_W | Character presented to the printer |
| prn_strobe_n | output | 1 | Active-low strobe to the printer |
| prn_busy | input | 1 | Printer busy, asynchronous |
| timeout_flag | output | 1 | Last character saw no busy response |

## Verification
The bench builds the block with a 3-clock strobe, 2-clock setup and hold intervals, and a 20-clock timeout. With setup and hold above one clock, the bench can tell a minimum-length interval from an exact count. The short timeout lets a missing busy response run to its end within a few dozen cycles. The busy response is also varied in delay and length, down to a single-clock pulse, which tests whether a short busy pulse is still seen through the synchronizer.

// File: rtl/pp_pkg.sv
package pp_pkg;

    typedef enum logic [2:0] {
        PP_IDLE    = 3'd0,
        PP_SETUP   = 3'd1,
        PP_STROBE  = 3'd2,
        PP_HOLD    = 3'd3,
        PP_WAIT_HI = 3'd4,
        PP_WAIT_LO = 3'd5
    } pp_state_e;

    function automatic int unsigned pp_max4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/pp_busy_sync.sv
module pp_busy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl
    import pp_pkg::*;
#(
    parameter int SETUP_CYC   = 1,
    parameter int STROBE_CYC  = 4,
    parameter int HOLD_CYC    = 1,
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic busy_s,
    output logic ready,
    output logic load,
    output logic strobe_n,
    output logic timeout
);
    localparam int unsigned MAX_CNT = pp_max4(SETUP_CYC, STROBE_CYC, HOLD_CYC, TIMEOUT_CYC);
    localparam int CNT_W = $clog2(MAX_CNT + 1);

    pp_state_e state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic seen_q, seen_n;
    logic tmo_q, tmo_n;
    logic strobe_q;

    assign ready = (state == PP_IDLE) && !busy_s;
    assign load  = ready && in_valid;

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        seen_n  = seen_q;
        tmo_n   = tmo_q;
        if (busy_s && (state == PP_STROBE || state == PP_HOLD || state == PP_WAIT_HI))
            seen_n = 1'b1;
        case (state)
            PP_IDLE: begin
                if (load) begin
                    state_n = PP_SETUP;
                    cnt_n   = CNT_W'(SETUP_CYC - 1);
                    seen_n  = 1'b0;
                    tmo_n   = 1'b0;
                end
            end
            PP_SETUP: begin
                if (cnt == '0) begin
                    state_n = PP_STROBE;
                    cnt_n   = CNT_W'(STROBE_CYC - 1);
                end else cnt_n = cnt - 1'b1;
            end
            PP_STROBE: begin
                if (cnt == '0) begin
                    state_n = PP_HOLD;
                    cnt_n   = CNT_W'(HOLD_CYC - 1);
                end else cnt_n = cnt - 1'b1;
            end
            PP_HOLD: begin
                if (cnt == '0) begin
                    state_n = PP_WAIT_HI;
                    cnt_n   = CNT_W'(TIMEOUT_CYC - 1);
                end else cnt_n = cnt - 1'b1;
            end
            PP_WAIT_HI: begin
                if (seen_q || busy_s) begin
                    state_n = PP_WAIT_LO;
                end else if (cnt == '0) begin
                    state_n = PP_IDLE;
                    tmo_n   = 1'b1;
                end else cnt_n = cnt - 1'b1;
            end
            PP_WAIT_LO: begin
                if (!busy_s) state_n = PP_IDLE;
            end
            default: state_n = PP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PP_IDLE;
            cnt      <= '0;
            seen_q   <= 1'b0;
            tmo_q    <= 1'b0;
            strobe_q <= 1'b1;
        end else begin
            state    <= state_n;
            cnt      <= cnt_n;
            seen_q   <= seen_n;
            tmo_q    <= tmo_n;
            strobe_q <= (state_n != PP_STROBE);
        end
    end

    assign strobe_n = strobe_q;
    assign timeout  = tmo_q;
endmodule

// File: rtl/pp_data_hold.sv
module pp_data_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] d_i,
    output logic [DATA_W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst)       q_o <= '0;
        else if (load) q_o <= d_i;
    end
endmodule

// File: rtl/strobe_printer_port.sv
module strobe_printer_port #(
    parameter int DATA_W      = 8,
    parameter int SETUP_CYC   = 1,
    parameter int STROBE_CYC  = 4,
    parameter int HOLD_CYC    = 1,
    parameter int TIMEOUT_CYC = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic [DATA_W-1:0] prn_data,
    output logic              prn_strobe_n,
    input  logic              prn_busy,
    output logic              timeout_flag
);
    logic busy_s;
    logic load;

    pp_busy_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .async_i(prn_busy), .sync_o(busy_s)
    );

    pp_ctrl #(
        .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC),
        .HOLD_CYC(HOLD_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) i_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .busy_s(busy_s),
        .ready(in_ready), .load(load), .strobe_n(prn_strobe_n), .timeout(timeout_flag)
    );

    pp_data_hold #(.DATA_W(DATA_W)) i_hold (
        .clk(clk), .rst(rst), .load(load), .d_i(in_data), .q_o(prn_data)
    );
endmodule

// File: rtl/pp_checker.sv
module pp_checker #(
    parameter int DATA_W     = 8,
    parameter int STROBE_CYC = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              in_ready,
    input logic [DATA_W-1:0] prn_data,
    input logic              prn_strobe_n,
    input logic              prn_busy,
    input logic              timeout_flag
);
    logic [15:0] low_cnt;
    logic [1:0]  since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt   <= '0;
            since_rst <= '0;
        end else begin
            low_cnt <= prn_strobe_n ? 16'd0 : low_cnt + 16'd1;
            if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
        end
    end

    assert_load_on_accept_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (prn_data == $past(in_data)));

    assert_hold_without_accept_R3: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> $stable(prn_data));

    assert_strobe_width_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(prn_strobe_n) |-> (low_cnt == 16'(STROBE_CYC)));

    assert_no_ready_in_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        !prn_strobe_n |-> !in_ready);

    assert_ready_needs_busy_low_R5: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && in_ready) |-> !$past(prn_busy, 2));

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !timeout_flag);
endmodule

bind strobe_printer_port pp_checker #(.DATA_W(DATA_W), .STROBE_CYC(STROBE_CYC)) i_pp_checker (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .prn_data(prn_data), .prn_strobe_n(prn_strobe_n), .prn_busy(prn_busy),
    .timeout_flag(timeout_flag)
);

// File: tb/test_strobe_printer_port.sv
`timescale 1ns/1ps
module test_strobe_printer_port;
    localparam int DW   = 8;
    localparam int SET  = 2;
    localparam int STB  = 3;
    localparam int HLD  = 2;
    localparam int TMO  = 20;
    localparam int NVEC = 6;
    // each entry: character, busy delay after strobe rise, busy length
    localparam logic [23:0] VEC [NVEC] = '{
        {8'hA5, 8'd0, 8'd1}, {8'h3C, 8'd2, 8'd5}, {8'hFF, 8'd5, 8'd2},
        {8'h00, 8'd1, 8'd9}, {8'h81, 8'd0, 8'd3}, {8'h5A, 8'd7, 8'd1}
    };

    logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, prn_busy = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic in_ready, prn_strobe_n, timeout_flag;
    logic [DW-1:0] prn_data;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    strobe_printer_port #(.DATA_W(DW), .SETUP_CYC(SET), .STROBE_CYC(STB),
                          .HOLD_CYC(HLD), .TIMEOUT_CYC(TMO)) i_strobe_printer_port (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .prn_data(prn_data), .prn_strobe_n(prn_strobe_n), .prn_busy(prn_busy),
        .timeout_flag(timeout_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // offer a character, return at the negedge after it is taken
    task automatic offer(input logic [DW-1:0] d);
        in_valid = 1'b1;
        in_data  = d;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = ~d;
        check(prn_data == d, "R3 load", prn_data, d);
    endtask

    // watch setup and strobe; return at negedge where strobe is back high
    task automatic watch_strobe(input logic [DW-1:0] d);
        int n = 0;
        int w = 0;
        while (prn_strobe_n) begin n++; @(negedge clk); end
        check(n >= SET, "R3 setup", n, SET);
        while (!prn_strobe_n) begin
            if (prn_data != d) check(1'b0, "R3 stable in strobe", prn_data, d);
            w++;
            @(negedge clk);
        end
        check(w == STB, "R4 strobe width", w, STB);
    endtask

    task automatic serve(input logic [DW-1:0] d, input int dly, input int len);
        int lows = 0;
        watch_strobe(d);
        for (int i = 0; i < dly; i++) begin
            if (in_ready || !prn_strobe_n) lows++;
            @(negedge clk);
        end
        prn_busy = 1'b1;
        for (int i = 0; i < len; i++) begin
            if (in_ready || !prn_strobe_n) lows++;
            @(negedge clk);
        end
        check(lows == 0, "R5 ready low before busy done, R4 one pulse", lows, 0);
        check(prn_data == d, "R3 held after strobe", prn_data, d);
        prn_busy = 1'b0;
        @(negedge clk); check(!in_ready, "R5 ready after 1", in_ready, 0);
        @(negedge clk); check(!in_ready, "R5 ready after 2", in_ready, 0);
        @(negedge clk); check(in_ready,  "R5 ready after 3", in_ready, 1);
        check(!timeout_flag, "R7 no timeout", timeout_flag, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(prn_strobe_n && prn_data == '0 && !timeout_flag, "R1 in reset",
              {prn_strobe_n, prn_data}, 9'h100);
        rst = 1'b0;
        @(negedge clk);
        check(prn_strobe_n == 1'b1, "R1 strobe", prn_strobe_n, 1);
        check(prn_data == '0, "R1 data", prn_data, 0);
        check(!timeout_flag, "R1 flag", timeout_flag, 0);
        check(in_ready, "R1 R2 ready", in_ready, 1);

        for (int v = 0; v < NVEC; v++) begin
            offer(VEC[v][23:16]);
            serve(VEC[v][23:16], int'(VEC[v][15:8]), int'(VEC[v][7:0]));
        end

        // R6: valid while busy high is ignored
        prn_busy = 1'b1;
        repeat (3) @(negedge clk);
        check(!in_ready, "R2 R6 ready low on busy", in_ready, 0);
        in_valid = 1'b1;
        in_data  = 8'h77;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(prn_strobe_n && prn_data == 8'h5A, "R6 ignored",
                  {prn_strobe_n, prn_data}, {1'b1, 8'h5A});
        end
        in_valid = 1'b0;
        prn_busy = 1'b0;
        repeat (3) @(negedge clk);
        check(in_ready, "R6 ready after busy clears", in_ready, 1);
        check(prn_data == 8'h5A, "R6 data kept", prn_data, 8'h5A);

        // R7: no busy response
        begin
            int m = 0;
            offer(8'hC3);
            watch_strobe(8'hC3);
            while (!in_ready && m < 200) begin m++; @(negedge clk); end
            check(m == HLD + TMO, "R7 timeout length", m, HLD + TMO);
            check(timeout_flag, "R7 flag set", timeout_flag, 1);
            check(prn_data == 8'hC3, "R3 data kept after timeout", prn_data, 8'hC3);
        end

        // R8: next acceptance clears the flag
        offer(8'h19);
        check(!timeout_flag, "R8 flag cleared", timeout_flag, 0);
        serve(8'h19, 1, 2);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule